// File: doc/BRIEF.md
# Microcoded DRAM Cycle Sequencer

This block produces the strobe and address waveforms of DRAM bus cycles from a 64-entry array of 32-bit control words that software loads beforehand. Each word holds the levels of RAS, CAS, WE and OE for one clock. It also says which half of the address, row or column, goes out on the clock after it. Further bits mark the ends of a repeated run, ask the sequencer to wait on the memory, or end the run.

Software stages a word in a data register. It then writes a command naming an array index, and the staged word is copied into that entry. When an access request hits the bank, the sequencer starts at a fixed index for the access type. Plain reads start at 0, burst reads at 8 and writes at 24. It then steps through the array until it reaches a word marked last. Read and write runs have their own loop counts. A refresh request starts the run at index 48, and it wins over any access that arrives in the same cycle. After every run, the sequencer forces a programmable number of idle clocks.

Top module: `dram_useq`

## Requirements
- R1: Writing `cfg_din` with `cfg_din_we` stages a word. A command with `cfg_cmd_op` = 01 copies the staged word into array entry `cfg_cmd_idx`. Op 10 copies that entry back into the staged register, which is visible on `cfg_dout`. Ops 00 and 11 change nothing.
- R2: When the sequencer is idle and no idle time remains, `req_valid` with `req_hit` raises `req_ack` in that cycle, and the run begins on the next clock. A plain read starts at index 0 and a burst read at index 8. A write starts at index 24 whatever `req_burst` is. A request with `req_hit` low is never accepted.
- R3: Control-word bits [3:0] give the levels of RAS, CAS, WE and OE, from bit 3 down to bit 0. They drive `mem_ras_n`, `mem_cas_n`, `mem_we_n` and `mem_oe_n` during the clock the word executes. When the sequencer is idle, all four strobes are high.
- R4: Control-word bits [5:4] choose the address for the clock after the word: 00 gives the row, 01 gives the column, and 1x keeps the current choice.
- R5: The first clock of a run drives the column when `cfg_sam` is 1, and the row when it is 0.
- R6: The column width is 8 + `cfg_cols` bits, so code 001 gives 9 bits. The column is the low bits of the latched address and the row is the remaining upper bits. `mem_addr` is zero when the sequencer is idle and during refresh.
- R7: Bit 6 marks a loop. The first marked word opens the loop and the next marked word closes it. The body between them, inclusive, runs max(N,1) times, where N is `cfg_rd_loops` for reads and burst reads, `cfg_wr_loops` for writes, and 0 for refresh.
- R8: While a word with bit 7 set executes and `mem_wait` is high, that word is held on the outputs for another clock.
- R9: A word with bit 8 set ends the run. `done` pulses during that word, and `busy` falls on the next clock.
- R10: When a request is waiting, the number of idle clocks between the last word of one run and the first word of the next is `cfg_dis` + 1.
- R11: A refresh request is accepted between runs with `refresh_ack`, and its run starts at index 48. It takes priority over an access request presented in the same cycle. That access is accepted after the refresh run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_din | input | 32 | Word to stage |
| cfg_din_we | input | 1 | Load the staged word register |
| cfg_cmd_we | input | 1 | Issue a command |
| cfg_cmd_op | input | 2 | Command: 01 store, 10 fetch |
| cfg_cmd_idx | input | 6 | Array index for the command |
| cfg_dout | output | 32 | Staged word register |
| cfg_sam | input | 1 | First-clock address choice (1 = column) |
| cfg_cols | input | 3 | Column width code (8 + code bits) |
| cfg_rd_loops | input | 4 | Loop count for read runs |
| cfg_wr_loops | input | 4 | Loop count for write runs |
| cfg_dis | input | 2 | Idle clocks after a run, minus one |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | Access is a write |
| req_burst | input | 1 | Access is a burst |
| req_hit | input | 1 | Bank decode hit |
| req_addr | input | 20 | Access address |
| req_ack | output | 1 | Access accepted this cycle |
| refresh_req | input | 1 | Refresh request |
| refresh_ack | output | 1 | Refresh accepted this cycle |
| mem_wait | input | 1 | Memory asks to hold a wait-sampling word |
| mem_ras_n | output | 1 | Row strobe |
| mem_cas_n | output | 1 | Column strobe |
| mem_we_n | output | 1 | Write enable |
| mem_oe_n | output | 1 | Output enable |
| mem_addr | output | 12 | Multiplexed row or column address |
| busy | output | 1 | A run is executing |
| done | output | 1 | Last word executing |

## Verification
Five properties are checked on every cycle:
- a store command lands in the array on the next clock;
- an access is never acknowledged while a refresh is pending;
- `busy` drops after a last word;
- outputs freeze while a wait-sampling word stalls;
- a refresh run begins with a zero address.

The shape of each waveform can only be shown by the scenarios. This covers loop repetition counts, the one-clock-late effect of the address choice, the column split and the exact idle gaps. In those scenarios, a scoreboard compares every busy cycle against a walk of the loaded microcode.

// File: rtl/dram_useq.sv
module dram_useq #(
  parameter int WORD_W    = 32,
  parameter int DEPTH     = 64,
  parameter int ADDR_W    = 20,
  parameter int MA_W      = 12,
  parameter int LOOP_W    = 4,
  parameter int RD_START  = 0,
  parameter int BRD_START = 8,
  parameter int WR_START  = 24,
  parameter int REF_START = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cfg_din,
  input  logic              cfg_din_we,
  input  logic              cfg_cmd_we,
  input  logic [1:0]        cfg_cmd_op,
  input  logic [$clog2(DEPTH)-1:0] cfg_cmd_idx,
  output logic [WORD_W-1:0] cfg_dout,
  input  logic              cfg_sam,
  input  logic [2:0]        cfg_cols,
  input  logic [LOOP_W-1:0] cfg_rd_loops,
  input  logic [LOOP_W-1:0] cfg_wr_loops,
  input  logic [1:0]        cfg_dis,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_burst,
  input  logic              req_hit,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ack,
  input  logic              refresh_req,
  output logic              refresh_ack,
  input  logic              mem_wait,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [MA_W-1:0]   mem_addr,
  output logic              busy,
  output logic              done
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [1:0] OP_STORE = 2'b01;
  localparam logic [1:0] OP_FETCH = 2'b10;

  logic [WORD_W-1:0] ucode [DEPTH];
  logic [WORD_W-1:0] stage_q;
  logic [IDX_W-1:0]  pc_q, loop_pc_q;
  logic [LOOP_W-1:0] loop_cnt_q;
  logic [1:0]        dis_q;
  logic [ADDR_W-1:0] addr_q;
  logic              run_q, col_q, in_loop_q;

  logic [WORD_W-1:0] word;
  logic [3:0]        w_stb;
  logic [1:0]        w_amx;
  logic              w_mark, w_wait, w_last;
  logic              unused_bits;

  assign word        = ucode[pc_q];
  assign w_stb       = word[3:0];
  assign w_amx       = word[5:4];
  assign w_mark      = word[6];
  assign w_wait      = word[7];
  assign w_last      = word[8];
  assign unused_bits = ^word[WORD_W-1:9];

  logic accept, ref_go, acc_go, stall, step;
  assign accept      = !run_q && dis_q == 2'd0;
  assign ref_go      = accept && refresh_req;
  assign acc_go      = accept && !refresh_req && req_valid && req_hit;
  assign stall       = run_q && w_wait && mem_wait;
  assign step        = run_q && !stall;

  assign req_ack     = acc_go;
  assign refresh_ack = ref_go;
  assign busy        = run_q;
  assign done        = step && w_last;
  assign cfg_dout    = stage_q;

  assign {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n} = run_q ? w_stb : 4'hF;

  logic [4:0]        ncol;
  logic [ADDR_W-1:0] row_full, col_full;
  assign ncol     = 5'd8 + {2'b00, cfg_cols};
  assign row_full = addr_q >> ncol;
  assign col_full = addr_q & ~({ADDR_W{1'b1}} << ncol);
  assign mem_addr = !run_q ? '0 : (col_q ? col_full[MA_W-1:0] : row_full[MA_W-1:0]);

  logic [IDX_W-1:0] acc_start;
  assign acc_start = req_write ? IDX_W'(WR_START)
                   : (req_burst ? IDX_W'(BRD_START) : IDX_W'(RD_START));

  always_ff @(posedge clk) begin
    if (cfg_cmd_we && cfg_cmd_op == OP_STORE) ucode[cfg_cmd_idx] <= stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else if (cfg_din_we) stage_q <= cfg_din;
    else if (cfg_cmd_we && cfg_cmd_op == OP_FETCH) stage_q <= ucode[cfg_cmd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q      <= 1'b0;
      pc_q       <= '0;
      loop_pc_q  <= '0;
      loop_cnt_q <= '0;
      in_loop_q  <= 1'b0;
      col_q      <= 1'b0;
      dis_q      <= 2'd0;
      addr_q     <= '0;
    end else if (ref_go) begin
      run_q      <= 1'b1;
      pc_q       <= IDX_W'(REF_START);
      loop_cnt_q <= '0;
      in_loop_q  <= 1'b0;
      col_q      <= cfg_sam;
      addr_q     <= '0;
    end else if (acc_go) begin
      run_q      <= 1'b1;
      pc_q       <= acc_start;
      loop_cnt_q <= req_write ? cfg_wr_loops : cfg_rd_loops;
      in_loop_q  <= 1'b0;
      col_q      <= cfg_sam;
      addr_q     <= req_addr;
    end else if (step) begin
      if (w_amx == 2'b00) col_q <= 1'b0;
      else if (w_amx == 2'b01) col_q <= 1'b1;
      if (w_last) begin
        run_q <= 1'b0;
        dis_q <= cfg_dis;
      end else if (w_mark && in_loop_q && loop_cnt_q > LOOP_W'(1)) begin
        loop_cnt_q <= loop_cnt_q - 1'b1;
        pc_q       <= loop_pc_q;
        in_loop_q  <= 1'b0;
      end else begin
        pc_q <= pc_q + 1'b1;
        if (w_mark) begin
          in_loop_q <= !in_loop_q;
          if (!in_loop_q) loop_pc_q <= pc_q;
        end
      end
    end else if (!run_q && dis_q != 2'd0) begin
      dis_q <= dis_q - 1'b1;
    end
  end

  // R1
  store_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cmd_we && cfg_cmd_op == OP_STORE) |=> ucode[$past(cfg_cmd_idx)] == $past(stage_q));

  // R11
  refresh_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> !refresh_req);

  // R11
  refresh_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ack |=> busy && mem_addr == '0);

  // R9
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> busy && $stable(mem_addr) && $stable({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}));
endmodule

// File: tb/dram_useq_bench.sv
`timescale 1ns/1ps
module dram_useq_bench;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [31:0] cfg_din = 0, cfg_dout;
  logic        cfg_din_we = 0, cfg_cmd_we = 0;
  logic [1:0]  cfg_cmd_op = 0;
  logic [5:0]  cfg_cmd_idx = 0;
  logic        cfg_sam = 0;
  logic [2:0]  cfg_cols = 3'd1;
  logic [3:0]  cfg_rd_loops = 4'd3, cfg_wr_loops = 4'd2;
  logic [1:0]  cfg_dis = 2'd0;
  logic        req_valid = 0, req_write = 0, req_burst = 0, req_hit = 0;
  logic [19:0] req_addr = 0;
  logic        req_ack, refresh_req = 0, refresh_ack, mem_wait = 0;
  logic        mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, busy, done;
  logic [11:0] mem_addr;

  dram_useq u_dram_useq (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] img [64];
  logic [16:0] sbq [$];
  bit gap_chk = 0;
  int exp_gap = 0, idle_n = 0;
  logic prev_busy = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit last, bit wt, bit mark, logic [1:0] amx, logic [3:0] stb);
    return {23'd0, last, wt, mark, amx, stb};
  endfunction

  // expected run: walk the loaded microcode
  task automatic push_run(int st, int loops, bit sam, logic [19:0] a, int ncol, int wait_idx, int wextra);
    int pc = st, lpc = 0, cnt = loops, guard = 0;
    bit sel = sam, inl = 0;
    logic [19:0] row = a >> ncol;
    logic [19:0] col = a & ~(20'hFFFFF << ncol);
    logic [31:0] w;
    while (guard < 200) begin
      int reps;
      guard++;
      w = img[pc];
      reps = (pc == wait_idx) ? 1 + wextra : 1;
      for (int r = 0; r < reps; r++)
        sbq.push_back({w[8] && (r == reps - 1), w[3:0], sel ? col[11:0] : row[11:0]});
      if (w[5:4] == 2'b00) sel = 0; else if (w[5:4] == 2'b01) sel = 1;
      if (w[8]) break;
      if (w[6] && inl && cnt > 1) begin cnt--; pc = lpc; inl = 0; end
      else begin
        if (w[6]) begin if (!inl) lpc = pc; inl = !inl; end
        pc++;
      end
    end
  endtask

  // monitor: R3 R4 R5 R6 R7 R9 per busy cycle, R10 gap
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (!prev_busy && gap_chk) begin
          chk("R10 idle gap", idle_n, exp_gap);
          gap_chk = 0;
        end
        if (sbq.size() == 0) chk("R9 unexpected busy cycle", 32'd1, 32'd0);
        else chk("R3 R4 R5 R6 R7 R9 cycle", {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_addr, done}, {sbq[0][15:0], sbq[0][16]});
        if (sbq.size() != 0) void'(sbq.pop_front());
        idle_n = 0;
      end else begin
        idle_n++;
        if (done) chk("R9 done while idle", 32'd1, 32'd0);
      end
      prev_busy = busy;
    end
  end

  task automatic load(int idx, logic [31:0] w);
    @(negedge clk); cfg_din = w; cfg_din_we = 1;
    @(negedge clk); cfg_din_we = 0; cfg_cmd_we = 1; cfg_cmd_op = 2'b01; cfg_cmd_idx = 6'(idx);
    @(negedge clk); cfg_cmd_we = 0;
    img[idx] = w;
  endtask

  task automatic fetch(int idx);
    @(negedge clk); cfg_cmd_we = 1; cfg_cmd_op = 2'b10; cfg_cmd_idx = 6'(idx);
    @(negedge clk); cfg_cmd_we = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic access(bit wr, bit bst, logic [19:0] a, int waitx);
    int st = wr ? 24 : (bst ? 8 : 0);
    push_run(st, wr ? int'(cfg_wr_loops) : int'(cfg_rd_loops), cfg_sam, a, 8 + cfg_cols,
             (bst && !wr) ? 9 : -1, waitx);
    @(negedge clk); req_valid = 1; req_write = wr; req_burst = bst; req_addr = a; req_hit = 1;
    #1; while (!req_ack) begin @(negedge clk); #1; end
    @(negedge clk); req_valid = 0;
    if (waitx > 0) begin repeat (3) @(negedge clk); mem_wait = 0; end
    wait_idle();
  endtask

  task automatic ref_then(bit wr, logic [19:0] a, int gap);
    push_run(48, 0, cfg_sam, 20'd0, 8 + cfg_cols, -1, 0);
    push_run(wr ? 24 : 0, wr ? int'(cfg_wr_loops) : int'(cfg_rd_loops), cfg_sam, a, 8 + cfg_cols, -1, 0);
    @(negedge clk); refresh_req = 1; req_valid = 1; req_write = wr; req_burst = 0; req_addr = a; req_hit = 1;
    #1;
    chk("R11 refresh wins", {refresh_ack, req_ack}, 2'b10);
    @(negedge clk); refresh_req = 0; #1; gap_chk = 1; exp_gap = gap;
    while (!req_ack) begin @(negedge clk); #1; end
    @(negedge clk); req_valid = 0;
    wait_idle();
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 idle strobes", {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}, 4'hF);
    chk("R6 idle address", mem_addr, 0);
    chk("R9 reset not busy", {busy, done}, 0);
    chk("R1 staged reset", cfg_dout, 0);

    load(0, mk(0,0,0,2'b01,4'b0111)); load(1, mk(0,0,1,2'b10,4'b0010));
    load(2, mk(0,0,1,2'b10,4'b0110)); load(3, mk(1,0,0,2'b00,4'b1111));
    load(8, mk(0,0,0,2'b01,4'b0111)); load(9, mk(0,1,0,2'b10,4'b0010));
    load(10, mk(0,0,0,2'b00,4'b0110)); load(11, mk(1,0,0,2'b10,4'b1111));
    load(24, mk(0,0,0,2'b01,4'b0111)); load(25, mk(0,0,1,2'b10,4'b0001));
    load(26, mk(0,0,1,2'b10,4'b0101)); load(27, mk(1,0,0,2'b00,4'b1111));
    load(48, mk(0,0,0,2'b10,4'b1011)); load(49, mk(0,0,0,2'b10,4'b0011));
    load(50, mk(1,0,0,2'b00,4'b1111));

    // R1 store and fetch
    fetch(25); #1; chk("R1 fetch entry 25", cfg_dout, img[25]);
    fetch(48); #1; chk("R1 fetch entry 48", cfg_dout, img[48]);
    @(negedge clk); cfg_din = 32'hDEAD_BEEF; cfg_din_we = 1;
    @(negedge clk); cfg_din_we = 0; cfg_cmd_we = 1; cfg_cmd_op = 2'b00; cfg_cmd_idx = 6'd25;
    @(negedge clk); cfg_cmd_op = 2'b11;
    @(negedge clk); cfg_cmd_we = 0;
    fetch(25); #1; chk("R1 ops 00/11 ignored", cfg_dout, img[25]);

    // R2 bank miss ignored
    @(negedge clk); req_valid = 1; req_hit = 0; req_addr = 20'h12345;
    repeat (5) begin @(negedge clk); #1; chk("R2 miss no ack", {req_ack, busy}, 2'b00); end
    req_valid = 0;

    // R2 R4 R5 R6 R7: plain read, 9 columns, 3 loops, row first
    access(0, 0, 20'hABCDE, 0);
    // R5 R8: burst read, column first, two wait clocks
    cfg_sam = 1; mem_wait = 1;
    access(0, 1, 20'h5A5A5, 2);
    // R2 R6 R7: write ignores burst, 11 columns, 2 loops
    cfg_sam = 0; cfg_cols = 3'd3;
    access(1, 1, 20'hF0F0F, 0);
    // R7: loop count 0 gives one pass
    cfg_wr_loops = 4'd0; cfg_rd_loops = 4'd1;
    access(1, 0, 20'h0137F, 0);
    access(0, 0, 20'h80001, 0);
    // R10 R11: refresh wins, then access after the forced gap
    cfg_cols = 3'd1; cfg_rd_loops = 4'd3; cfg_wr_loops = 4'd2;
    cfg_dis = 2'd1; ref_then(0, 20'h3C3C3, 2);
    cfg_dis = 2'd3; ref_then(1, 20'hC3C3C, 4);
    cfg_dis = 2'd0; ref_then(0, 20'h00FFF, 1);

    chk("R9 all runs consumed", sbq.size(), 0);
    chk("R3 final idle strobes", {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}, 4'hF);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule